// File: doc/BRIEF.md
# Autovectored FIFO Interrupt Vector Substitution

This block gathers fourteen FIFO-flag and waveform-engine interrupt lines into a single interrupt request for an 8-bit processor. It resolves the unmasked pending lines by fixed priority and turns the winner into a vector byte. The vector byte is the low byte of an entry in a handler jump table whose high byte the software keeps in code memory.

The block sits on the processor's code-fetch path. When the processor takes the interrupt, it pushes its program counter and jumps to a fixed entry address. At that address it expects a jump instruction. The operand's high byte is read from memory unchanged. When vector substitution is enabled, the fetch of the operand's low byte at the slot address returns the latched vector instead of the memory byte. The jump therefore lands on one of fourteen handlers in the same page.

The vector is captured on the interrupt acknowledge. A source that rises or falls while the jump instruction is being fetched cannot change the target.

Top module: `fifo_irq_autovector`

## Requirements
- R1: `irq_req` is high in the same cycle whenever at least one source has `src_req` high and its `src_mask` bit low. It is low otherwise.
- R2: A source whose `src_mask` bit is 1 never raises `irq_req` and never wins priority, even when its request is high.
- R3: Source index 0 has the highest priority and index 13 the lowest. The index order is: indices 0..3 are the four programmable flags, 4..7 the four empty flags, 8..11 the four full flags, 12 is waveform done and 13 is the waveform event. The vector for index i is 0x80 + 4*i, so the range is 0x80 to 0xB4.
- R4: If no unmasked source is pending when `irq_ack` is sampled, the captured vector is 0x80.
- R5: `vec_out` takes the vector of the winning source at the rising edge where `irq_ack` is high. It holds that value unchanged until the next such edge, whatever the sources do in between.
- R6: With `av_en` = 1, `fetch_stb` = 1 and `fetch_addr` = 0x0555, `cpu_rdata` equals `vec_out` in the same cycle.
- R7: With `av_en` = 0, `cpu_rdata` equals `mem_rdata` for every address, including 0x0555.
- R8: A fetch at any address other than 0x0555 passes `mem_rdata` through unchanged. This includes the entry address 0x0553 and the page byte at 0x0554.
- R9: With `fetch_stb` = 0, `cpu_rdata` equals `mem_rdata`.
- R10: After reset `vec_out` is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 14 | Source request lines, index 0 is highest priority |
| src_mask | input | 14 | Per-source mask, 1 removes the source |
| av_en | input | 1 | Vector substitution enable |
| irq_ack | input | 1 | Interrupt acknowledge, captures the vector |
| fetch_addr | input | 16 | Code fetch address |
| fetch_stb | input | 1 | Code fetch strobe |
| mem_rdata | input | 8 | Byte returned by code memory |
| irq_req | output | 1 | Combined interrupt request |
| cpu_rdata | output | 8 | Byte delivered to the processor |
| vec_out | output | 8 | Latched vector byte |

## Verification
A wrong priority chain or a broken mask shows up on `vec_out` in the first cycle after an acknowledge. It shows up at once on `cpu_rdata` during a slot fetch, where the wrong handler offset appears. A capture register that is not held shows as a `vec_out` change while `irq_ack` is low. The bench and the checker both see this within one cycle of the source change. A wrong address decode corrupts a pass-through byte at 0x0553 or 0x0554 in the same cycle as the fetch, or fails to insert the vector at 0x0555.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] vbyte_t;

  // Vector byte for a winning source index.
  function automatic vbyte_t vec_of(input int unsigned idx,
                                    input vbyte_t base,
                                    input int unsigned step);
    return vbyte_t'(base + vbyte_t'(step * idx));
  endfunction
endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned N_SRC = 14,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] grant,
  output logic [IW-1:0]    win_idx
);
  // Prefix "someone above is pending" chain, index 0 on top.
  logic [N_SRC-1:0] above;

  assign above[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N_SRC; g++) begin : g_chain
      assign above[g] = above[g-1] | pend[g-1];
    end
  endgenerate

  assign grant = pend & ~above;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqv_vec_hold.sv
module irqv_vec_hold
  import irqv_pkg::*;
#(
  parameter int unsigned N_SRC    = 14,
  parameter vbyte_t      VEC_BASE = 8'h80,
  parameter int unsigned VEC_STEP = 4,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic [IW-1:0] win_idx,
  output vbyte_t        live_vec,
  output vbyte_t        held_vec
);
  // With nothing pending the index is 0, giving the base vector.
  assign live_vec = vec_of(int'(win_idx), VEC_BASE, VEC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_vec <= VEC_BASE;
    else if (ack) held_vec <= live_vec;
  end
endmodule

// File: rtl/irqv_fetch_dec.sv
module irqv_fetch_dec #(
  parameter int unsigned  AW        = 16,
  parameter logic [AW-1:0] SLOT_ADDR = 16'h0555
) (
  input  logic          av_en,
  input  logic          fetch_stb,
  input  logic [AW-1:0] fetch_addr,
  output logic          slot_hit
);
  assign slot_hit = av_en & fetch_stb & (fetch_addr == SLOT_ADDR);
endmodule

// File: rtl/fifo_irq_autovector.sv
module fifo_irq_autovector
  import irqv_pkg::*;
#(
  parameter int unsigned   N_SRC     = 14,
  parameter int unsigned   AW        = 16,
  parameter vbyte_t        VEC_BASE  = 8'h80,
  parameter int unsigned   VEC_STEP  = 4,
  parameter logic [AW-1:0] SLOT_ADDR = 16'h0555
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_req,
  input  logic [N_SRC-1:0]    src_mask,
  input  logic                av_en,
  input  logic                irq_ack,
  input  logic [AW-1:0]       fetch_addr,
  input  logic                fetch_stb,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                irq_req,
  output logic [BYTE_W-1:0]   cpu_rdata,
  output logic [BYTE_W-1:0]   vec_out
);
  localparam int unsigned IW = $clog2(N_SRC);

  // Named internal events, observed by the bound checker.
  logic [N_SRC-1:0] w_pend;
  logic [N_SRC-1:0] w_grant;
  logic [IW-1:0]    w_win_idx;
  vbyte_t           w_live_vec;
  vbyte_t           w_held_vec;
  logic             w_slot_hit;

  assign w_pend = src_req & ~src_mask;

  irqv_prio #(.N_SRC(N_SRC)) u_prio (
    .pend    (w_pend),
    .grant   (w_grant),
    .win_idx (w_win_idx)
  );

  irqv_vec_hold #(
    .N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (irq_ack),
    .win_idx  (w_win_idx),
    .live_vec (w_live_vec),
    .held_vec (w_held_vec)
  );

  irqv_fetch_dec #(.AW(AW), .SLOT_ADDR(SLOT_ADDR)) u_dec (
    .av_en      (av_en),
    .fetch_stb  (fetch_stb),
    .fetch_addr (fetch_addr),
    .slot_hit   (w_slot_hit)
  );

  assign irq_req   = |w_grant;
  assign vec_out   = w_held_vec;
  assign cpu_rdata = w_slot_hit ? w_held_vec : mem_rdata;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int unsigned   N_SRC     = 14,
  parameter int unsigned   AW        = 16,
  parameter logic [7:0]    VEC_BASE  = 8'h80,
  parameter logic [AW-1:0] SLOT_ADDR = 16'h0555
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_mask,
  input logic             av_en,
  input logic             irq_ack,
  input logic [AW-1:0]    fetch_addr,
  input logic             fetch_stb,
  input logic [7:0]       mem_rdata,
  input logic             irq_req,
  input logic [7:0]       cpu_rdata,
  input logic [7:0]       vec_out,
  input logic [N_SRC-1:0] w_pend,
  input logic [N_SRC-1:0] w_grant,
  input logic [7:0]       w_live_vec
);
  p_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (w_pend != '0));

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_grant & src_mask) == '0);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(w_grant));

  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req) |=> vec_out == VEC_BASE);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> vec_out == $past(w_live_vec));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> $stable(vec_out));

  p_subst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (av_en && fetch_stb && fetch_addr == SLOT_ADDR) |-> cpu_rdata == vec_out);

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !av_en |-> cpu_rdata == mem_rdata);

  p_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr != SLOT_ADDR) |-> cpu_rdata == mem_rdata);

  p_nostb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |-> cpu_rdata == mem_rdata);
endmodule

bind fifo_irq_autovector irqv_checker #(
  .N_SRC(N_SRC), .AW(AW), .VEC_BASE(VEC_BASE), .SLOT_ADDR(SLOT_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_mask   (src_mask),
  .av_en      (av_en),
  .irq_ack    (irq_ack),
  .fetch_addr (fetch_addr),
  .fetch_stb  (fetch_stb),
  .mem_rdata  (mem_rdata),
  .irq_req    (irq_req),
  .cpu_rdata  (cpu_rdata),
  .vec_out    (vec_out),
  .w_pend     (w_pend),
  .w_grant    (w_grant),
  .w_live_vec (w_live_vec)
);

// File: tb/fifo_irq_autovector_tb.sv
module fifo_irq_autovector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_req = '0;
  logic [13:0] src_mask = '0;
  logic        av_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_stb = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        irq_req;
  logic [7:0]  cpu_rdata;
  logic [7:0]  vec_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fifo_irq_autovector u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
    .av_en(av_en), .irq_ack(irq_ack), .fetch_addr(fetch_addr),
    .fetch_stb(fetch_stb), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .cpu_rdata(cpu_rdata), .vec_out(vec_out)
  );

  // Bench model: the first unmasked pending line, counted from index 0, picks the vector.
  function automatic logic [7:0] model_vec(input logic [13:0] req, input logic [13:0] msk);
    for (int k = 0; k < 14; k++)
      if (req[k] && !msk[k]) return 8'h80 + 8'(k << 2);
    return 8'h80;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 reset vector", vec_out, 8'h80);
    chk("R1 reset req idle", {7'd0, irq_req}, 8'd0);
  endtask

  task automatic t_req_or();
    @(negedge clk) src_req = 14'h2000; src_mask = '0; #1;
    chk("R1 lowest source raises req", {7'd0, irq_req}, 8'd1);
    src_req = 14'h0; #1;
    chk("R1 no source drops req", {7'd0, irq_req}, 8'd0);
  endtask

  task automatic t_priority();
    for (int i = 0; i < 14; i++) begin
      // Source i plus every lower-priority line.
      @(negedge clk) src_req = 14'h3FFF << i; src_mask = '0;
      do_ack();
      chk($sformatf("R3 priority idx %0d", i), vec_out, 8'h80 + 8'(4 * i));
    end
    @(negedge clk) src_req = 14'b10_0100_0001_0000;
    do_ack();
    chk("R3 scattered pattern", vec_out, model_vec(14'b10_0100_0001_0000, '0));
  endtask

  task automatic t_mask();
    @(negedge clk) src_req = 14'h0003; src_mask = 14'h0001;
    do_ack();
    chk("R2 masked top loses", vec_out, 8'h84);
    @(negedge clk) src_req = 14'h0100; src_mask = 14'h0100; #1;
    chk("R2 masked only source no req", {7'd0, irq_req}, 8'd0);
    src_mask = '0;
  endtask

  task automatic t_none();
    @(negedge clk) src_req = 14'h0800;
    do_ack();
    chk("R4 setup", vec_out, 8'hAC);
    @(negedge clk) src_req = '0;
    do_ack();
    chk("R4 none pending gives base", vec_out, 8'h80);
  endtask

  task automatic t_hold();
    @(negedge clk) src_req = 14'h0040;
    do_ack();
    chk("R5 captured", vec_out, 8'h98);
    @(negedge clk) src_req = 14'h0001;
    @(negedge clk) src_req = 14'h0000;
    @(negedge clk) src_req = 14'h2000; #1;
    chk("R5 held across source change", vec_out, 8'h98);
  endtask

  task automatic t_fetch();
    // vec_out is 0x98 here.
    @(negedge clk) av_en = 1'b1; fetch_stb = 1'b1; mem_rdata = 8'h3C;
    fetch_addr = 16'h0555; #1;
    chk("R6 slot substituted", cpu_rdata, 8'h98);
    fetch_addr = 16'h0554; #1;
    chk("R8 page byte untouched", cpu_rdata, 8'h3C);
    fetch_addr = 16'h0553; #1;
    chk("R8 entry byte untouched", cpu_rdata, 8'h3C);
    fetch_addr = 16'h1555; #1;
    chk("R8 alias address untouched", cpu_rdata, 8'h3C);
    fetch_addr = 16'h0555; fetch_stb = 1'b0; #1;
    chk("R9 no strobe passes", cpu_rdata, 8'h3C);
    fetch_stb = 1'b1; av_en = 1'b0; mem_rdata = 8'h5A; #1;
    chk("R7 disabled passes", cpu_rdata, 8'h5A);
    av_en = 1'b1; #1;
    chk("R6 re-enabled substitutes", cpu_rdata, 8'h98);
    @(negedge clk) fetch_stb = 1'b0; av_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_req_or();
    t_priority();
    t_mask();
    t_none();
    t_hold();
    t_fetch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule